// File: doc/BRIEF.md
# Indexed Sign-Extending Word Load Unit

This unit carries out one indexed word load. It forms an effective address from a base operand and an index operand. A zero-base select replaces the base with a literal zero. The unit then reads a 4-byte word over a request/grant memory port with a separate read-valid response. It places the four bytes in big- or little-endian order and sign-extends the 32-bit word to a 64-bit result.

A facility-enable input is checked when a load is accepted. If the facility is off, the unit raises a one-cycle unavailable exception and touches no memory. The unit takes a new load only when it is idle, so at most one memory request is ever outstanding. It alters no status state of its own beyond the result register and the two strobes.

Top module: `sxw_load_unit`

## Requirements
- R1: A load accepted while `fac_en_i` is 0 pulses `exc_o` for one cycle on the clock edge after acceptance. It drives no `mem_req_o` for that load and gives no `done_o`.
- R2: When `base_zero_i` is 1, the address issued on `mem_addr_o` equals `index_i`, whatever `base_i` holds.
- R3: When `base_zero_i` is 0, the address issued equals `base_i + index_i` modulo 2^64 (carry out of bit 63 is dropped).
- R4: Memory data lane k (`mem_rdata_i[8k+7:8k]`) holds the byte at address EA+k. With `big_endian_i` = 1, the byte at EA becomes bits 31:24 of the loaded word, and the byte at EA+3 becomes bits 7:0.
- R5: With `big_endian_i` = 0, the byte at EA becomes bits 7:0 of the loaded word, and the byte at EA+3 becomes bits 31:24.
- R6: `result_o[63:32]` equals 32 copies of bit 31 of the loaded word, and `result_o[31:0]` is the loaded word.
- R7: `ready_o` is 1 only when idle. A `start_i` while `ready_o` is 0 is ignored, so only one memory request is outstanding.
- R8: Once raised, `mem_req_o` stays high with a stable `mem_addr_o` until the cycle `mem_gnt_i` is sampled high.
- R9: `done_o` pulses for exactly one cycle, on the clock edge after `mem_rvalid_i` is sampled, with `result_o` valid in that cycle. `done_o` and `exc_o` are never high together.
- R10: After reset, `ready_o` is 1, `mem_req_o`, `done_o` and `exc_o` are 0, and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load request, taken when `ready_o` is 1 |
| base_zero_i | input | 1 | Use a literal zero in place of the base operand |
| base_i | input | 64 | Base operand |
| index_i | input | 64 | Index operand |
| big_endian_i | input | 1 | Byte order select: 1 big-endian, 0 little-endian |
| fac_en_i | input | 1 | Facility enable |
| ready_o | output | 1 | Idle and able to take a load |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 64 | Effective address of the word |
| mem_gnt_i | input | 1 | Request accepted by memory |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data, lane k is the byte at EA+k |
| result_o | output | 64 | Sign-extended loaded word |
| done_o | output | 1 | One-cycle load completion strobe |
| exc_o | output | 1 | One-cycle facility-unavailable strobe |

## Verification
The hardest case to reach is a `start_i` that arrives while a load is still waiting for its grant or its data. The bench has to show that this start produces neither a second request nor a stray exception. To get there, the memory responder stalls the grant and the data for several cycles. While it stalls, the bench pulses `start_i` with the facility both on and off. The scoreboard then flags any completion or exception it did not expect. The responder also varies the grant and data latencies, so the request-hold rule is checked across multi-cycle stalls. The addresses used include a carry past bit 63.

// File: rtl/sxw_pkg.sv
package sxw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } sxw_state_e;
endpackage

// File: rtl/sxw_ea_gen.sv
module sxw_ea_gen #(
  parameter int XLEN = 64
) (
  input  logic            base_zero_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] index_i,
  output logic [XLEN-1:0] ea_o
);
  logic [XLEN-1:0] base_eff;

  assign base_eff = base_zero_i ? '0 : base_i;
  // carry out of the top bit is dropped: modulo 2^XLEN
  assign ea_o     = base_eff + index_i;
endmodule

// File: rtl/sxw_lane_order.sv
module sxw_lane_order #(
  parameter int NBYTES = 4,
  localparam int WW = 8 * NBYTES
) (
  input  logic          big_endian_i,
  input  logic [WW-1:0] lanes_i,
  output logic [WW-1:0] word_o
);
  logic [WW-1:0] be_word;
  logic [WW-1:0] le_word;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign le_word[8*k +: 8]            = lanes_i[8*k +: 8];
    assign be_word[8*(NBYTES-1-k) +: 8] = lanes_i[8*k +: 8];
  end

  assign word_o = big_endian_i ? be_word : le_word;
endmodule

// File: rtl/sxw_sext.sv
module sxw_sext #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 64
) (
  input  logic [IN_W-1:0]  word_i,
  output logic [OUT_W-1:0] ext_o
);
  localparam int PAD_W = OUT_W - IN_W;

  assign ext_o = {{PAD_W{word_i[IN_W-1]}}, word_i};
endmodule

// File: rtl/sxw_ctrl.sv
module sxw_ctrl
  import sxw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fac_en_i,
  input  logic mem_gnt_i,
  input  logic mem_rvalid_i,
  output logic ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic mem_req_o,
  output logic done_o,
  output logic exc_o
);
  sxw_state_e state_q, state_d;
  logic       fault;
  logic       done_q, exc_q;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o & start_i & fac_en_i;
  assign fault     = ready_o & start_i & ~fac_en_i;
  assign mem_req_o = (state_q == ST_REQ);
  assign capture_o = (state_q == ST_WAIT) & mem_rvalid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o)     state_d = ST_REQ;
      ST_REQ:  if (mem_gnt_i)    state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid_i) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= capture_o;
      exc_q   <= fault;
    end
  end

  assign done_o = done_q;
  assign exc_o  = exc_q;
endmodule

// File: rtl/sxw_load_unit.sv
module sxw_load_unit #(
  parameter int XLEN       = 64,
  parameter int WORD_BYTES = 4,
  localparam int WW = 8 * WORD_BYTES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            base_zero_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] index_i,
  input  logic            big_endian_i,
  input  logic            fac_en_i,
  output logic            ready_o,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [WW-1:0]   mem_rdata_i,
  output logic [XLEN-1:0] result_o,
  output logic            done_o,
  output logic            exc_o
);
  logic [XLEN-1:0] ea;
  logic [XLEN-1:0] addr_q;
  logic            be_q;
  logic            accept, capture;
  logic [WW-1:0]   word;
  logic [XLEN-1:0] ext;
  logic [XLEN-1:0] result_q;

  sxw_ea_gen #(.XLEN(XLEN)) u_ea (
    .base_zero_i(base_zero_i),
    .base_i     (base_i),
    .index_i    (index_i),
    .ea_o       (ea)
  );

  sxw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .fac_en_i    (fac_en_i),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i),
    .ready_o     (ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .mem_req_o   (mem_req_o),
    .done_o      (done_o),
    .exc_o       (exc_o)
  );

  sxw_lane_order #(.NBYTES(WORD_BYTES)) u_lanes (
    .big_endian_i(be_q),
    .lanes_i     (mem_rdata_i),
    .word_o      (word)
  );

  sxw_sext #(.IN_W(WW), .OUT_W(XLEN)) u_sext (
    .word_i(word),
    .ext_o (ext)
  );

  // operands captured at accept; inputs may change while the load is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      be_q     <= 1'b0;
      result_q <= '0;
    end else begin
      if (accept) begin
        addr_q <= ea;
        be_q   <= big_endian_i;
      end
      if (capture) result_q <= ext;
    end
  end

  assign mem_addr_o = addr_q;
  assign result_o   = result_q;
endmodule

// File: rtl/sxw_load_unit_chk.sv
module sxw_load_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            fac_en_i,
  input logic            ready_o,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_gnt_i,
  input logic            mem_rvalid_i,
  input logic [XLEN-1:0] result_o,
  input logic            done_o,
  input logic            exc_o
);
  a_r1_exc_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && !fac_en_i) |=> (exc_o && !mem_req_o && !done_o));

  a_r6_sign_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}}));

  a_r7_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);

  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r9_done_after_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_rvalid_i));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_exc_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && exc_o));
endmodule

bind sxw_load_unit sxw_load_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .fac_en_i    (fac_en_i),
  .ready_o     (ready_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_rvalid_i(mem_rvalid_i),
  .result_o    (result_o),
  .done_o      (done_o),
  .exc_o       (exc_o)
);

// File: tb/sxw_load_unit_bench.sv
`timescale 1ns/1ps
module sxw_load_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, base_zero = 1'b0, big_endian = 1'b0, fac_en = 1'b0;
  logic [63:0] base = '0, index = '0;
  logic        ready, mem_req, done, exc;
  logic [63:0] mem_addr, result;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int n_issued = 0;
  int n_seen = 0;
  int gdly = 0;
  int rdly = 0;
  bit finished = 0;

  logic [63:0] exp_res_q[$];
  bit          exp_exc_q[$];
  string       exp_tag_q[$];
  logic [63:0] exp_addr_q[$];
  string       exp_atag_q[$];

  always #4 clk = ~clk;

  sxw_load_unit u_sxw_load_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_zero_i(base_zero),
    .base_i(base), .index_i(index), .big_endian_i(big_endian), .fac_en_i(fac_en),
    .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .result_o(result),
    .done_o(done), .exc_o(exc)
  );

  function automatic logic [7:0] mbyte(logic [63:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[63:56] ^ 8'hC3;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: waits for idle, issues one load, pushes expectations
  task automatic do_load(bit zsel, logic [63:0] b, logic [63:0] ix, bit be, bit fen);
    logic [63:0] ea;
    logic [31:0] w;
    logic [7:0]  by [4];
    ea = (zsel ? 64'd0 : b) + ix;
    for (int k = 0; k < 4; k++) by[k] = mbyte(ea + 64'(k));
    w = be ? {by[0], by[1], by[2], by[3]} : {by[3], by[2], by[1], by[0]};
    @(negedge clk);
    while (!ready) @(negedge clk);
    start = 1'b1; base_zero = zsel; base = b; index = ix; big_endian = be; fac_en = fen;
    if (fen) begin
      exp_addr_q.push_back(ea);
      exp_atag_q.push_back(zsel ? "R2" : "R3");
      exp_res_q.push_back({{32{w[31]}}, w});
      exp_exc_q.push_back(1'b0);
      exp_tag_q.push_back(be ? (w[31] ? "R4/R6" : "R4") : (w[31] ? "R5/R6" : "R5"));
    end else begin
      exp_res_q.push_back(64'd0);
      exp_exc_q.push_back(1'b1);
      exp_tag_q.push_back("R1");
    end
    n_issued++;
    @(negedge clk);
    start = 1'b0;
    base = ~base; index = ~index; big_endian = ~big_endian;
  endtask

  // memory responder with variable grant/data latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && rst_n) begin
        logic [63:0] a, ea_e;
        string t;
        a = mem_addr;
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R1", a, 64'd0);
        end else begin
          ea_e = exp_addr_q.pop_front();
          t = exp_atag_q.pop_front();
          chk(a == ea_e, t, a, ea_e);
        end
        for (int i = 0; i < gdly; i++) begin
          @(negedge clk);
          chk(mem_req && mem_addr == a, "R8", mem_addr, a);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int i = 0; i < rdly; i++) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata = {mbyte(a + 64'd3), mbyte(a + 64'd2), mbyte(a + 64'd1), mbyte(a)};
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata = 32'hDEAD_BEEF;
      end
    end
  end

  // monitor: compares outputs against scoreboard
  initial begin
    bit prev_done = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done && exc) chk(1'b0, "R9", 64'd1, 64'd0);
        if (done && prev_done) chk(1'b0, "R9", 64'd1, 64'd0);
        if (done || exc) begin
          n_seen++;
          if (exp_exc_q.size() == 0) begin
            chk(1'b0, "R7", {62'd0, done, exc}, 64'd0);
          end else begin
            logic [63:0] er;
            bit ee;
            string t;
            er = exp_res_q.pop_front();
            ee = exp_exc_q.pop_front();
            t  = exp_tag_q.pop_front();
            if (ee) chk(exc && !done, t, {62'd0, done, exc}, 64'd1);
            else begin
              chk(done && !exc, "R9", {62'd0, done, exc}, 64'd2);
              chk(result == er, t, result, er);
            end
          end
        end
        prev_done = done;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk(ready && !mem_req && !done && !exc && result == 64'd0, "R10",
        {59'd0, ready, mem_req, done, exc, |result}, 64'h10);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !mem_req && !done && !exc && result == 64'd0, "R10",
        {59'd0, ready, mem_req, done, exc, |result}, 64'h10);

    // directed: zero base ignores base operand (R2)
    do_load(1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0100, 1'b1, 1'b1);
    do_load(1'b1, 64'hFFFF_0000_FFFF_0000, 64'h0000_0000_0000_0100, 1'b0, 1'b1);
    // wrap past 2^64 (R3)
    do_load(1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd5, 1'b1, 1'b1);
    do_load(1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0040, 1'b0, 1'b1);
    // facility off (R1)
    do_load(1'b0, 64'h10, 64'h20, 1'b1, 1'b0);
    do_load(1'b1, 64'h10, 64'h20, 1'b0, 1'b0);

    // busy start is ignored (R7): long stall, then pulse start both ways
    gdly = 3; rdly = 3;
    do_load(1'b0, 64'h4000, 64'h33, 1'b1, 1'b1);
    chk(!ready, "R7", {63'd0, ready}, 64'd0);
    start = 1'b1; fac_en = 1'b0;
    @(negedge clk);
    fac_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!ready, "R7", {63'd0, ready}, 64'd0);

    // varied stimulus across latencies and endianness
    for (int i = 0; i < 40; i++) begin
      gdly = i % 3; rdly = (i / 3) % 3;
      do_load(i[0], {$urandom, $urandom}, {$urandom, $urandom}, i[1], (i % 7) != 3);
    end

    repeat (20) @(negedge clk);
    chk(exp_res_q.size() == 0 && exp_addr_q.size() == 0, "R7",
        64'(exp_res_q.size()), 64'd0);
    chk(n_seen == n_issued, "R7", 64'(n_seen), 64'(n_issued));
    chk(ready && !mem_req, "R7", {62'd0, ready, mem_req}, 64'd2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule